// File: doc/BRIEF.md
# Compliance-Test Bus Memory with Signature and Trigger Ports

This block is a Wishbone classic slave that sits beside a processor under architectural test. It holds the program and data image in a word-organised RAM that starts at address zero, the processor's reset address. The RAM is split into four independent byte-wide arrays, so each array holds one quarter of the capacity. Before the processor starts fetching, a simple load port fills the RAM one whole word at a time from the executable image.

Two fixed addresses above the RAM give the test program a way to talk to the bench. A store to the signature address does not touch the RAM. Instead, the stored word appears as a one-cycle valid/data beat on the signature stream, in the order the stores happen. A store to the trigger address updates three machine-level interrupt request levels: software, timer and external. The same store can also raise a one-cycle end-of-simulation strobe.

Top module: `wb_test_mem`

## Requirements
- R1: While the reset is asserted, and after it is released, ack, sig_valid, sim_finish, irq_msi, irq_mti and irq_mei are all low.
- R2: Each Wishbone request (wb_cyc and wb_stb both high) receives exactly one ack, one clock cycle after the request is accepted. ack is low in the following cycle, and read data is valid in the ack cycle.
- R3: Addresses below 4*DEPTH_WORDS select the RAM. The word index is wb_adr[log2(DEPTH_WORDS)+1:2], and a read returns all four byte lanes, whatever wb_sel holds.
- R4: A RAM write changes only the byte lanes whose wb_sel bit is set. Lane n holds bits [8n+7:8n] of the word.
- R5: A load-port write (ld_en high) stores all 32 bits of ld_data at word ld_addr. A Wishbone RAM write accepted in the same cycle is dropped, although it is still acknowledged.
- R6: A write to 0xF0000004 leaves the RAM unchanged. It raises sig_valid for one cycle, in the ack cycle, with sig_data equal to the full written word, and successive writes come out in order. A read of this address returns zero.
- R7: At the trigger address 0xF0000000, written bits 0, 1 and 2 set irq_msi, irq_mti and irq_mei. These levels hold until the register is written again. A read returns them in bits [2:0], and all other bits read as zero.
- R8: A trigger write with bit 31 set raises sim_finish for exactly one cycle, in the ack cycle.
- R9: An access to any other address is acknowledged, reads as zero, and changes neither the RAM nor the interrupt levels.
- R10: The interrupt levels change only in the cycle after a trigger write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_cyc | input | 1 | Bus cycle active |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Write enable |
| wb_adr | input | 32 | Byte address |
| wb_dat_w | input | 32 | Write data |
| wb_sel | input | 4 | Byte-lane select |
| wb_dat_r | output | 32 | Read data, valid with ack |
| wb_ack | output | 1 | Acknowledge |
| ld_en | input | 1 | Load-port write enable |
| ld_addr | input | log2(DEPTH_WORDS) | Load-port word index |
| ld_data | input | 32 | Load-port word |
| sig_valid | output | 1 | Signature beat valid |
| sig_data | output | 32 | Signature word |
| sim_finish | output | 1 | End-of-simulation strobe |
| irq_msi | output | 1 | Machine software interrupt level |
| irq_mti | output | 1 | Machine timer interrupt level |
| irq_mei | output | 1 | Machine external interrupt level |

## Verification
The assertions check the following on every cycle:
- ack is single and follows a request.
- Signature beats and the finish strobe line up with ack.
- The finish strobe lasts one cycle.
- The interrupt levels move only after a trigger write.

The bench scenarios cover what no cycle-local property can show:
- The stored contents: preloaded words read back, and byte-select merges for every one of the sixteen select patterns.
- The load port winning over a colliding bus write.
- Aliasing of the special and out-of-range addresses onto the RAM, and the order of signature words.

// File: rtl/tm_pkg.sv
package tm_pkg;
  localparam int unsigned LANES = 4;
  localparam logic [31:0] SIG_ADDR = 32'hF000_0004;
  localparam logic [31:0] TRG_ADDR = 32'hF000_0000;
  localparam int unsigned TRG_MSI_BIT = 0;
  localparam int unsigned TRG_MTI_BIT = 1;
  localparam int unsigned TRG_MEI_BIT = 2;
  localparam int unsigned TRG_FIN_BIT = 31;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_RAM  = 2'd1,
    RGN_SIG  = 2'd2,
    RGN_TRG  = 2'd3
  } rgn_e;
endpackage

// File: rtl/tm_rst_sync.sv
module tm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/tm_addr_dec.sv
module tm_addr_dec
  import tm_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic [31:0] adr,
  output rgn_e        rgn
);
  logic in_ram;

  assign in_ram = (adr[31:AW+2] == '0);

  always_comb begin
    if (in_ram)               rgn = RGN_RAM;
    else if (adr == SIG_ADDR) rgn = RGN_SIG;
    else if (adr == TRG_ADDR) rgn = RGN_TRG;
    else                      rgn = RGN_NONE;
  end
endmodule

// File: rtl/tm_byte_lane.sv
module tm_byte_lane #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tm_trigger.sv
module tm_trigger (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] irq_wr,
  input  logic       fin_wr,
  output logic [2:0] irq,
  output logic       finish
);
  logic [2:0] irq_d;
  logic       fin_d;

  always_comb begin
    irq_d = irq;
    fin_d = 1'b0;
    if (wr_en) begin
      irq_d = irq_wr;
      fin_d = fin_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq    <= '0;
      finish <= 1'b0;
    end else begin
      irq    <= irq_d;
      finish <= fin_d;
    end
  end

  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(irq));
  p_finish_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !finish);
endmodule

// File: rtl/wb_test_mem.sv
module wb_test_mem
  import tm_pkg::*;
#(
  parameter int unsigned DEPTH_WORDS = 256,
  localparam int unsigned AW = $clog2(DEPTH_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wb_cyc,
  input  logic          wb_stb,
  input  logic          wb_we,
  input  logic [31:0]   wb_adr,
  input  logic [31:0]   wb_dat_w,
  input  logic [3:0]    wb_sel,
  output logic [31:0]   wb_dat_r,
  output logic          wb_ack,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [31:0]   ld_data,
  output logic          sig_valid,
  output logic [31:0]   sig_data,
  output logic          sim_finish,
  output logic          irq_msi,
  output logic          irq_mti,
  output logic          irq_mei
);
  logic srst_n;
  rgn_e rgn, rd_rgn_q, rd_rgn_d;
  logic req, acc, ram_wr, ram_rd, trg_wr, sig_wr;
  logic ack_q, ack_d, sig_v_q, sig_v_d;
  logic [31:0] sig_d_q, sig_d_d, ram_q;
  logic [AW-1:0] word_idx;
  logic [2:0] irq_vec;

  tm_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  tm_addr_dec #(.AW(AW)) u_dec (.adr(wb_adr), .rgn(rgn));

  assign req      = wb_cyc & wb_stb;
  assign acc      = req & ~ack_q;
  assign word_idx = wb_adr[AW+1:2];
  assign ram_wr   = acc & wb_we & (rgn == RGN_RAM) & ~ld_en;
  assign ram_rd   = acc & ~wb_we & (rgn == RGN_RAM);
  assign trg_wr   = acc & wb_we & (rgn == RGN_TRG);
  assign sig_wr   = acc & wb_we & (rgn == RGN_SIG);

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    logic          l_we;
    logic [AW-1:0] l_waddr;
    logic [7:0]    l_wdata;

    assign l_we    = ld_en | (ram_wr & wb_sel[n]);
    assign l_waddr = ld_en ? ld_addr : word_idx;
    assign l_wdata = ld_en ? ld_data[8*n +: 8] : wb_dat_w[8*n +: 8];

    tm_byte_lane #(.DEPTH(DEPTH_WORDS)) u_lane (
      .clk  (clk),
      .we   (l_we),
      .waddr(l_waddr),
      .wdata(l_wdata),
      .re   (ram_rd),
      .raddr(word_idx),
      .rdata(ram_q[8*n +: 8])
    );
  end

  tm_trigger u_trg (
    .clk   (clk),
    .rst_n (srst_n),
    .wr_en (trg_wr),
    .irq_wr({wb_dat_w[TRG_MEI_BIT], wb_dat_w[TRG_MTI_BIT], wb_dat_w[TRG_MSI_BIT]}),
    .fin_wr(wb_dat_w[TRG_FIN_BIT]),
    .irq   (irq_vec),
    .finish(sim_finish)
  );

  always_comb begin
    ack_d    = acc;
    sig_v_d  = sig_wr;
    sig_d_d  = sig_wr ? wb_dat_w : sig_d_q;
    rd_rgn_d = rd_rgn_q;
    if (acc) rd_rgn_d = wb_we ? RGN_NONE : rgn;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ack_q    <= 1'b0;
      sig_v_q  <= 1'b0;
      sig_d_q  <= '0;
      rd_rgn_q <= RGN_NONE;
    end else begin
      ack_q    <= ack_d;
      sig_v_q  <= sig_v_d;
      sig_d_q  <= sig_d_d;
      rd_rgn_q <= rd_rgn_d;
    end
  end

  always_comb begin
    case (rd_rgn_q)
      RGN_RAM: wb_dat_r = ram_q;
      RGN_TRG: wb_dat_r = {29'd0, irq_vec};
      default: wb_dat_r = '0;
    endcase
  end

  assign wb_ack    = ack_q;
  assign sig_valid = sig_v_q;
  assign sig_data  = sig_d_q;
  assign irq_msi   = irq_vec[0];
  assign irq_mti   = irq_vec[1];
  assign irq_mei   = irq_vec[2];

  p_ack_after_req_r2: assert property (@(posedge clk) disable iff (!srst_n)
    wb_ack |-> $past(wb_cyc && wb_stb));
  p_ack_single_r2: assert property (@(posedge clk) disable iff (!srst_n)
    wb_ack |=> !wb_ack);
  p_sig_with_ack_r6: assert property (@(posedge clk) disable iff (!srst_n)
    sig_valid |-> wb_ack);
  p_finish_with_ack_r8: assert property (@(posedge clk) disable iff (!srst_n)
    sim_finish |-> wb_ack);
endmodule

// File: tb/wb_test_mem_test.sv
module wb_test_mem_test;
  localparam int unsigned D  = 16;
  localparam int unsigned AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
  logic [31:0] wb_adr = '0, wb_dat_w = '0;
  logic [3:0] wb_sel = '0;
  logic [31:0] wb_dat_r;
  logic wb_ack;
  logic ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic sig_valid, sim_finish, irq_msi, irq_mti, irq_mei;
  logic [31:0] sig_data;

  int tests = 0, fails = 0;
  logic [31:0] model [D];
  logic [31:0] rd;
  logic sv, fin;
  logic [31:0] sd;

  always #5 clk = ~clk;

  wb_test_mem #(.DEPTH_WORDS(D)) uut (
    .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_sel(wb_sel), .wb_dat_r(wb_dat_r),
    .wb_ack(wb_ack), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .sig_valid(sig_valid), .sig_data(sig_data), .sim_finish(sim_finish),
    .irq_msi(irq_msi), .irq_mti(irq_mti), .irq_mei(irq_mei)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input logic we, input logic [31:0] adr, input logic [31:0] dat,
                     input logic [3:0] sel);
    @(negedge clk);
    wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = we; wb_adr = adr; wb_dat_w = dat; wb_sel = sel;
    @(negedge clk);
    chk("R2 ack", {31'd0, wb_ack}, 32'd1);
    rd = wb_dat_r; sv = sig_valid; sd = sig_data; fin = sim_finish;
    wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
    @(negedge clk);
    chk("R2 single ack", {31'd0, wb_ack}, 32'd0);
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'h1F2E3D4C ^ (i * 32'h01030507);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1 reset state; preload while reset is held (R5)
    @(negedge clk);
    chk("R1 reset outs", {26'd0, wb_ack, sig_valid, sim_finish, irq_msi, irq_mti, irq_mei}, 32'd0);
    for (int i = 0; i < D; i++) begin
      ld_en = 1'b1; ld_addr = AW'(i); ld_data = pat(i); model[i] = pat(i);
      @(negedge clk);
    end
    ld_en = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset", {26'd0, wb_ack, sig_valid, sim_finish, irq_msi, irq_mti, irq_mei}, 32'd0);

    // R3/R5 read back preloaded image, sel ignored on reads
    for (int i = 0; i < D; i++) begin
      bus(1'b0, 32'(i * 4), 32'd0, 4'(i));
      chk("R3/R5 preload readback", rd, model[i]);
    end

    // R4 byte-select sweep over all 16 patterns
    for (int s = 0; s < 16; s++) begin
      logic [31:0] d;
      d = 32'hA0B0C0D0 + 32'(s);
      bus(1'b1, 32'(s * 4), d, 4'(s));
      for (int n = 0; n < 4; n++)
        if (s[n]) model[s][8*n +: 8] = d[8*n +: 8];
    end
    for (int s = 0; s < 16; s++) begin
      bus(1'b0, 32'(s * 4), 32'd0, 4'hF);
      chk("R4 byte merge", rd, model[s]);
    end

    // R9 out-of-range address: acked, reads zero, no RAM/irq effect
    bus(1'b1, 32'h0000_0040, 32'hDEAD_BEEF, 4'hF);
    bus(1'b1, 32'h0000_0100, 32'h0000_0007, 4'hF);
    bus(1'b0, 32'h0000_0040, 32'd0, 4'hF);
    chk("R9 unmapped read", rd, 32'd0);
    chk("R9 irq untouched", {29'd0, irq_mei, irq_mti, irq_msi}, 32'd0);
    bus(1'b0, 32'h0, 32'd0, 4'hF);
    chk("R9 ram word0 intact", rd, model[0]);

    // R6 signature stream
    for (int k = 0; k < 3; k++) begin
      bus(1'b1, 32'hF000_0004, 32'h5150_0000 + 32'(k), 4'h1);
      chk("R6 sig valid", {31'd0, sv}, 32'd1);
      chk("R6 sig data order", sd, 32'h5150_0000 + 32'(k));
    end
    chk("R6 sig pulse ends", {31'd0, sig_valid}, 32'd0);
    bus(1'b0, 32'hF000_0004, 32'd0, 4'hF);
    chk("R6 sig read zero", rd, 32'd0);
    bus(1'b0, 32'h4, 32'd0, 4'hF);
    chk("R6 ram untouched", rd, model[1]);

    // R7/R10 trigger sweep of all interrupt combinations
    for (int v = 0; v < 8; v++) begin
      bus(1'b1, 32'hF000_0000, 32'hFFFF_FFF8 - 32'h8000_0000 + 32'(v), 4'hF);
      chk("R7 irq levels", {29'd0, irq_mei, irq_mti, irq_msi}, 32'(v));
      bus(1'b0, 32'hF000_0000, 32'd0, 4'hF);
      chk("R7 trigger read", rd, 32'(v));
      chk("R10 irq held over read", {29'd0, irq_mei, irq_mti, irq_msi}, 32'(v));
    end

    // R8 finish strobe
    chk("R8 no finish yet", {31'd0, sim_finish}, 32'd0);
    bus(1'b1, 32'hF000_0000, 32'h8000_0002, 4'hF);
    chk("R8 finish with ack", {31'd0, fin}, 32'd1);
    chk("R8 finish one cycle", {31'd0, sim_finish}, 32'd0);
    chk("R8 irq after finish write", {29'd0, irq_mei, irq_mti, irq_msi}, 32'd2);

    // R5 load port wins over colliding bus write
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 4'd3; ld_data = 32'h0BAD_F00D;
    wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b1; wb_adr = 32'hC; wb_dat_w = 32'h1234_5678; wb_sel = 4'hF;
    @(negedge clk);
    ld_en = 1'b0;
    chk("R5 collided write acked", {31'd0, wb_ack}, 32'd1);
    wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
    model[3] = 32'h0BAD_F00D;
    bus(1'b0, 32'hC, 32'd0, 4'hF);
    chk("R5 load priority", rd, model[3]);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule